// File: doc/BRIEF.md
# Task-File I/O Address Decoder

This block sits between a storage controller's host port and its register file. It turns each host I/O cycle into a single select line for the register that the cycle targets. Its inputs are the address, the attribute-space qualifier, the two chip selects and the two I/O strobes. The register file behind it then only has to act on one select and a read or write qualifier.

The host picks one of four decode schemes with a 2-bit input. Two schemes are fixed windows, one high (task file at 1F0h, control pair at 3F6h) and one low (task file at 170h, control pair at 376h). The third is a 16-entry window that looks only at the low four address bits. The fourth is a chip-select scheme for direct drive attachment. The same offset can reach a different register depending on whether the cycle reads or writes. An active-low 16-bit indication tells the host when a data port is being addressed.

All outputs are registered and follow the sampled inputs by one clock.

Top module: `tf_io_decode`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sel_o` is zero, `rd_o` and `wr_o` are low and `iois16_n_o` is high.
- R2: Outputs change only at a rising clock edge, and they reflect the inputs sampled at that edge. Changing an input between edges leaves the outputs unchanged until the next edge.
- R3: With `map_mode`=00, addresses 1F0h+k (k=0..7) decode as task-file offset k. 3F6h decodes as the control pair and 3F7h as the drive-address slot. Every other address selects nothing.
- R4: With `map_mode`=01, the R3 decode applies at 170h+k, 376h and 377h instead.
- R5: With `map_mode`=10, only `addr[3:0]` is decoded and `addr[10:4]` has no effect. Offsets 0..7 are the task file, E is the control pair and F is the drive-address slot. Offsets A, B and C select nothing.
- R6: The `sel_o` bit positions are: 0 data, 1 error, 2 feature, 3 sector count, 4 sector number, 5 cylinder low, 6 cylinder high, 7 drive/head, 8 status, 9 command, 10 alternate status, 11 device control, 12 drive address, 13 duplicate even data, 14 duplicate odd data. Offset 1 selects bit 1 on read and bit 2 on write. Offset 7 selects bit 8 on read and bit 9 on write. The control pair selects bit 10 on read and bit 11 on write. The drive-address slot selects bit 12 on read and nothing on write. Offsets 2..6 select bits 3..7 in both directions.
- R7: In `map_mode`=10, offset 8 selects bit 13, offset 9 selects bit 14, and offset D behaves like offset 1, in both directions.
- R8: In `map_mode` 00, 01 and 10, a cycle with `reg_n` high selects nothing.
- R9: In `map_mode` 00, 01 and 10, a cycle with `io_en` low selects nothing.
- R10: With `map_mode`=11, `reg_n`, `io_en` and `addr[10:3]` have no effect. `cs0_n` low with `cs1_n` high selects task-file offset `addr[2:0]`. `cs1_n` low with `cs0_n` high and `addr[2:0]`=6 selects the control pair. Any other chip-select pattern selects nothing.
- R11: A cycle is a read when only `iord_n` is low and a write when only `iowr_n` is low. With both strobes low or both high nothing is selected. `rd_o` or `wr_o` is high exactly when a select bit is set.
- R12: `iois16_n_o` is low exactly when bit 0, 13 or 14 of `sel_o` is set.
- R13: At most one bit of `sel_o` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| map_mode | input | 2 | Decode scheme: 00 high window, 01 low window, 10 four-bit window, 11 chip-select |
| io_en | input | 1 | I/O interface configured; gates the three windowed schemes |
| reg_n | input | 1 | Attribute-space qualifier, active low for I/O cycles |
| addr | input | 11 | Host address |
| cs0_n | input | 1 | Task-file chip select in chip-select scheme, active low |
| cs1_n | input | 1 | Control-pair chip select in chip-select scheme, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| sel_o | output | 15 | One-hot register select |
| rd_o | output | 1 | Selected cycle is a read |
| wr_o | output | 1 | Selected cycle is a write |
| iois16_n_o | output | 1 | Data port addressed, active low |

## Verification
The hardest cases are the ones where a cycle looks valid in one field but is cancelled by another. Examples are a correct window address with `reg_n` high or `io_en` low, a write to the read-only drive-address slot, and both chip selects or both strobes asserted together. Any of these passes through a decode that a simple directed test rarely reaches. The stimulus sweeps every 11-bit address in both directions for each windowed scheme. It then replays the window hits with each cancelling qualifier. In the chip-select scheme it walks all four chip-select patterns and all four strobe patterns, while scrambling the upper address bits, `reg_n` and `io_en`.

// File: rtl/tf_pkg.sv
package tf_pkg;

    localparam int ADDR_W = 11;
    localparam int OFF_W  = 4;
    localparam int NSEL   = 15;
    localparam int NWIN   = 2;

    // select bit positions
    localparam int SEL_DATA    = 0;
    localparam int SEL_ERROR   = 1;
    localparam int SEL_FEATURE = 2;
    localparam int SEL_SECCNT  = 3;
    localparam int SEL_SECNUM  = 4;
    localparam int SEL_CYLLO   = 5;
    localparam int SEL_CYLHI   = 6;
    localparam int SEL_DRVHD   = 7;
    localparam int SEL_STATUS  = 8;
    localparam int SEL_COMMAND = 9;
    localparam int SEL_ALTSTAT = 10;
    localparam int SEL_DEVCTL  = 11;
    localparam int SEL_DRVADDR = 12;
    localparam int SEL_DUPEVEN = 13;
    localparam int SEL_DUPODD  = 14;

    // normalised offsets beyond the eight task-file slots
    localparam logic [OFF_W-1:0] OFF_DUPEVEN = 4'h8;
    localparam logic [OFF_W-1:0] OFF_DUPODD  = 4'h9;
    localparam logic [OFF_W-1:0] OFF_DUPERR  = 4'hD;
    localparam logic [OFF_W-1:0] OFF_CTLPAIR = 4'hE;
    localparam logic [OFF_W-1:0] OFF_DRVADDR = 4'hF;

    localparam logic [2:0] CS1_CTL_IDX = 3'd6;

    // window bases: index 0 high window, index 1 low window
    localparam logic [ADDR_W-1:0] WIN_TASK [NWIN] = '{11'h1F0, 11'h170};
    localparam logic [ADDR_W-1:0] WIN_CTL  [NWIN] = '{11'h3F6, 11'h376};

    typedef enum logic [1:0] {
        MAP_HIGH  = 2'b00,
        MAP_LOW   = 2'b01,
        MAP_NIB   = 2'b10,
        MAP_CHSEL = 2'b11
    } map_mode_e;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'b00,
        DIR_READ  = 2'b01,
        DIR_WRITE = 2'b10
    } dir_e;

    typedef logic [NSEL-1:0] sel_vec_t;

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] off;
    } loc_t;

    function automatic sel_vec_t sel_bit(input int idx);
        sel_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic dir_e strobe_dir(input logic rd_n, input logic wr_n);
        case ({rd_n, wr_n})
            2'b01:   return DIR_READ;
            2'b10:   return DIR_WRITE;
            default: return DIR_IDLE;
        endcase
    endfunction

    function automatic logic is_data_port(input sel_vec_t v);
        return v[SEL_DATA] | v[SEL_DUPEVEN] | v[SEL_DUPODD];
    endfunction

endpackage

// File: rtl/tf_win_match.sv
// Compares an address against one fixed task-file window and its control pair.
// TASK_BASE must be 8-aligned and CTL_BASE even.
module tf_win_match
    import tf_pkg::*;
#(
    parameter int            AW        = ADDR_W,
    parameter logic [AW-1:0] TASK_BASE = '0,
    parameter logic [AW-1:0] CTL_BASE  = '0
) (
    input  logic [AW-1:0] addr,
    output loc_t          loc
);

    logic task_hit;
    logic ctl_hit;

    assign task_hit = (addr[AW-1:3] == TASK_BASE[AW-1:3]);
    assign ctl_hit  = (addr[AW-1:1] == CTL_BASE[AW-1:1]);

    always_comb begin
        loc = '0;
        if (task_hit) begin
            loc.hit = 1'b1;
            loc.off = {1'b0, addr[2:0]};
        end else if (ctl_hit) begin
            loc.hit = 1'b1;
            loc.off = addr[0] ? OFF_DRVADDR : OFF_CTLPAIR;
        end
    end

endmodule

// File: rtl/tf_loc_mux.sv
// Reduces every decode scheme to one normalised offset in the 16-slot space.
module tf_loc_mux
    import tf_pkg::*;
(
    input  map_mode_e         mode,
    input  logic              io_en,
    input  logic              reg_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs0_n,
    input  logic              cs1_n,
    output loc_t              loc
);

    loc_t win_loc [NWIN];
    logic io_gate;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            tf_win_match #(
                .AW        (ADDR_W),
                .TASK_BASE (WIN_TASK[w]),
                .CTL_BASE  (WIN_CTL[w])
            ) u_win (
                .addr (addr),
                .loc  (win_loc[w])
            );
        end
    endgenerate

    assign io_gate = io_en & ~reg_n;

    always_comb begin
        loc = '0;
        case (mode)
            MAP_HIGH: begin
                if (io_gate) loc = win_loc[0];
            end
            MAP_LOW: begin
                if (io_gate) loc = win_loc[1];
            end
            MAP_NIB: begin
                if (io_gate) begin
                    loc.hit = 1'b1;
                    loc.off = addr[OFF_W-1:0];
                end
            end
            MAP_CHSEL: begin
                if (!cs0_n && cs1_n) begin
                    loc.hit = 1'b1;
                    loc.off = {1'b0, addr[2:0]};
                end else if (cs0_n && !cs1_n && addr[2:0] == CS1_CTL_IDX) begin
                    loc.hit = 1'b1;
                    loc.off = OFF_CTLPAIR;
                end
            end
            default: loc = '0;
        endcase
    end

endmodule

// File: rtl/tf_reg_map.sv
// Turns a normalised offset and cycle direction into a one-hot register select.
module tf_reg_map
    import tf_pkg::*;
(
    input  loc_t     loc,
    input  dir_e     dir,
    output sel_vec_t sel
);

    logic is_rd;

    assign is_rd = (dir == DIR_READ);

    always_comb begin
        sel = '0;
        if (loc.hit && dir != DIR_IDLE) begin
            case (loc.off)
                4'h0:        sel = sel_bit(SEL_DATA);
                4'h1,
                OFF_DUPERR:  sel = is_rd ? sel_bit(SEL_ERROR)   : sel_bit(SEL_FEATURE);
                4'h2:        sel = sel_bit(SEL_SECCNT);
                4'h3:        sel = sel_bit(SEL_SECNUM);
                4'h4:        sel = sel_bit(SEL_CYLLO);
                4'h5:        sel = sel_bit(SEL_CYLHI);
                4'h6:        sel = sel_bit(SEL_DRVHD);
                4'h7:        sel = is_rd ? sel_bit(SEL_STATUS)  : sel_bit(SEL_COMMAND);
                OFF_DUPEVEN: sel = sel_bit(SEL_DUPEVEN);
                OFF_DUPODD:  sel = sel_bit(SEL_DUPODD);
                OFF_CTLPAIR: sel = is_rd ? sel_bit(SEL_ALTSTAT) : sel_bit(SEL_DEVCTL);
                OFF_DRVADDR: sel = is_rd ? sel_bit(SEL_DRVADDR) : '0;
                default:     sel = '0;
            endcase
        end
    end

endmodule

// File: rtl/tf_io_decode.sv
module tf_io_decode
    import tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        map_mode,
    input  logic              io_en,
    input  logic              reg_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    output logic [NSEL-1:0]   sel_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              iois16_n_o
);

    map_mode_e mode;
    loc_t      loc;
    dir_e      dir;
    sel_vec_t  sel_d;
    sel_vec_t  sel_q;
    logic      rd_q;
    logic      wr_q;
    logic      iois16_n_q;

    assign mode = map_mode_e'(map_mode);
    assign dir  = strobe_dir(iord_n, iowr_n);

    tf_loc_mux u_loc (
        .mode  (mode),
        .io_en (io_en),
        .reg_n (reg_n),
        .addr  (addr),
        .cs0_n (cs0_n),
        .cs1_n (cs1_n),
        .loc   (loc)
    );

    tf_reg_map u_map (
        .loc (loc),
        .dir (dir),
        .sel (sel_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            rd_q       <= 1'b0;
            wr_q       <= 1'b0;
            iois16_n_q <= 1'b1;
        end else begin
            sel_q      <= sel_d;
            rd_q       <= (|sel_d) && (dir == DIR_READ);
            wr_q       <= (|sel_d) && (dir == DIR_WRITE);
            iois16_n_q <= ~is_data_port(sel_d);
        end
    end

    assign sel_o      = sel_q;
    assign rd_o       = rd_q;
    assign wr_o       = wr_q;
    assign iois16_n_o = iois16_n_q;

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_q == '0 && !rd_q && !wr_q && iois16_n_q));

    assert_onehot_sel_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_q));

    assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_q && wr_q));

    assert_qual_tracks_sel_R11: assert property (@(posedge clk) disable iff (rst)
        ((|sel_q) == (rd_q || wr_q)));

    assert_reg_high_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (map_mode != 2'b11 && reg_n) |=> (sel_q == '0));

    assert_io_disabled_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (map_mode != 2'b11 && !io_en) |=> (sel_q == '0));

    assert_dual_cs_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (map_mode == 2'b11 && !cs0_n && !cs1_n) |=> (sel_q == '0));

    assert_write_not_readonly_R6: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> !(sel_q[SEL_ERROR] || sel_q[SEL_STATUS] ||
                   sel_q[SEL_ALTSTAT] || sel_q[SEL_DRVADDR]));

    assert_iois_on_data_R12: assert property (@(posedge clk) disable iff (rst)
        !iois16_n_q |-> (sel_q[SEL_DATA] || sel_q[SEL_DUPEVEN] || sel_q[SEL_DUPODD]));

endmodule

// File: tb/tb_tf_io_decode.sv
module tb_tf_io_decode;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  map_mode;
    logic        io_en;
    logic        reg_n;
    logic [10:0] addr;
    logic        cs0_n;
    logic        cs1_n;
    logic        iord_n;
    logic        iowr_n;
    logic [14:0] sel_o;
    logic        rd_o;
    logic        wr_o;
    logic        iois16_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tf_io_decode dut (
        .clk        (clk),
        .rst        (rst),
        .map_mode   (map_mode),
        .io_en      (io_en),
        .reg_n      (reg_n),
        .addr       (addr),
        .cs0_n      (cs0_n),
        .cs1_n      (cs1_n),
        .iord_n     (iord_n),
        .iowr_n     (iowr_n),
        .sel_o      (sel_o),
        .rd_o       (rd_o),
        .wr_o       (wr_o),
        .iois16_n_o (iois16_n_o)
    );

    // reference: returns expected select bit, or -1 for no select
    function automatic int exp_bit(input logic [1:0] m, input logic ie, input logic rn,
                                   input logic [10:0] a, input logic c0, input logic c1,
                                   input logic rdn, input logic wrn);
        int  off;
        int  ai;
        bit  rd;
        bit  wr;
        off = -1;
        ai  = int'(a);
        rd  = !rdn && wrn;
        wr  = !wrn && rdn;
        if (!rd && !wr) return -1;
        if (m == 2'd3) begin
            if (!c0 && c1)                    off = ai % 8;
            else if (c0 && !c1 && ai % 8 == 6) off = 14;
        end else if (ie && !rn) begin
            if (m == 2'd2) begin
                off = ai % 16;
            end else begin
                int tbase;
                int cbase;
                tbase = (m == 2'd0) ? 'h1F0 : 'h170;
                cbase = (m == 2'd0) ? 'h3F6 : 'h376;
                if (ai >= tbase && ai < tbase + 8) off = ai - tbase;
                else if (ai == cbase)              off = 14;
                else if (ai == cbase + 1)          off = 15;
            end
        end
        case (off)
            0:       return 0;
            1, 13:   return rd ? 1 : 2;
            2:       return 3;
            3:       return 4;
            4:       return 5;
            5:       return 6;
            6:       return 7;
            7:       return rd ? 8 : 9;
            8:       return 13;
            9:       return 14;
            14:      return rd ? 10 : 11;
            15:      return rd ? 12 : -1;
            default: return -1;
        endcase
    endfunction

    // compare outputs against the inputs currently held (sampled at the last edge)
    task automatic check_now(input string tag);
        int          b;
        logic [14:0] es;
        logic        erd;
        logic        ewr;
        logic        eio;
        b   = exp_bit(map_mode, io_en, reg_n, addr, cs0_n, cs1_n, iord_n, iowr_n);
        es  = (b >= 0) ? (15'd1 << b) : 15'd0;
        erd = (b >= 0) && !iord_n;
        ewr = (b >= 0) && !iowr_n;
        eio = !(b == 0 || b == 13 || b == 14);
        checks++;
        if (sel_o !== es || rd_o !== erd || wr_o !== ewr) begin
            errors++;
            $display("FAIL %s mode=%0d addr=%h cs=%b%b strb=%b%b: sel=%h rd=%b wr=%b expected sel=%h rd=%b wr=%b",
                     tag, map_mode, addr, cs0_n, cs1_n, iord_n, iowr_n,
                     sel_o, rd_o, wr_o, es, erd, ewr);
        end
        checks++;
        if (iois16_n_o !== eio) begin
            errors++;
            $display("FAIL R12 mode=%0d addr=%h: iois16_n=%b expected %b",
                     map_mode, addr, iois16_n_o, eio);
        end
        checks++;
        if ($countones(sel_o) > 1) begin
            errors++;
            $display("FAIL R13 sel=%h: ones=%0d expected <=1", sel_o, $countones(sel_o));
        end
    endtask

    // drive at a falling edge, let one rising edge register it, check at the next falling edge
    task automatic apply(input string tag, input logic [1:0] m, input logic ie, input logic rn,
                         input logic [10:0] a, input logic c0, input logic c1,
                         input logic rdn, input logic wrn);
        map_mode = m; io_en = ie; reg_n = rn; addr = a;
        cs0_n = c0; cs1_n = c1; iord_n = rdn; iowr_n = wrn;
        @(negedge clk);
        check_now(tag);
    endtask

    task automatic expect_bit(input string tag, input int bitpos);
        checks++;
        if (bitpos < 0 ? (sel_o !== 15'd0) : (sel_o !== (15'd1 << bitpos))) begin
            errors++;
            $display("FAIL %s: sel=%h expected bit %0d", tag, sel_o, bitpos);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        map_mode = 2'd0; io_en = 1'b1; reg_n = 1'b0; addr = 11'h1F0;
        cs0_n = 1'b1; cs1_n = 1'b1; iord_n = 1'b0; iowr_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: outputs held clear during reset despite a valid cycle at the inputs
        checks++;
        if (sel_o !== 15'd0 || rd_o !== 1'b0 || wr_o !== 1'b0 || iois16_n_o !== 1'b1) begin
            errors++;
            $display("FAIL R1 in reset: sel=%h rd=%b wr=%b io=%b expected 0 0 0 1",
                     sel_o, rd_o, wr_o, iois16_n_o);
        end
        rst = 1'b0;
        iord_n = 1'b1;
        @(negedge clk);
        check_now("R1");

        // R2: input change between edges leaves outputs alone until the next edge
        addr = 11'h1F7; iord_n = 1'b0;
        #1;
        checks++;
        if (sel_o !== 15'd0) begin
            errors++;
            $display("FAIL R2 before edge: sel=%h expected 0000", sel_o);
        end
        @(negedge clk);
        expect_bit("R2 after edge", 8);

        // R6: direction-dependent registers, directed
        apply("R6", 2'd0, 1'b1, 1'b0, 11'h1F1, 1'b1, 1'b1, 1'b0, 1'b1); expect_bit("R6 error", 1);
        apply("R6", 2'd0, 1'b1, 1'b0, 11'h1F1, 1'b1, 1'b1, 1'b1, 1'b0); expect_bit("R6 feature", 2);
        apply("R6", 2'd0, 1'b1, 1'b0, 11'h1F7, 1'b1, 1'b1, 1'b1, 1'b0); expect_bit("R6 command", 9);
        apply("R6", 2'd1, 1'b1, 1'b0, 11'h376, 1'b1, 1'b1, 1'b0, 1'b1); expect_bit("R6 altstat", 10);
        apply("R6", 2'd1, 1'b1, 1'b0, 11'h376, 1'b1, 1'b1, 1'b1, 1'b0); expect_bit("R6 devctl", 11);
        apply("R6", 2'd0, 1'b1, 1'b0, 11'h3F7, 1'b1, 1'b1, 1'b0, 1'b1); expect_bit("R6 drvaddr", 12);
        apply("R6", 2'd0, 1'b1, 1'b0, 11'h3F7, 1'b1, 1'b1, 1'b1, 1'b0); expect_bit("R6 reserved", -1);
        apply("R6", 2'd0, 1'b1, 1'b0, 11'h1F4, 1'b1, 1'b1, 1'b1, 1'b0); expect_bit("R6 cyl low wr", 5);

        // R7: duplicate ports in the four-bit window
        apply("R7", 2'd2, 1'b1, 1'b0, 11'h7F8, 1'b1, 1'b1, 1'b1, 1'b0); expect_bit("R7 dup even", 13);
        apply("R7", 2'd2, 1'b1, 1'b0, 11'h009, 1'b1, 1'b1, 1'b0, 1'b1); expect_bit("R7 dup odd", 14);
        apply("R7", 2'd2, 1'b1, 1'b0, 11'h00D, 1'b1, 1'b1, 1'b1, 1'b0); expect_bit("R7 dup feature", 2);

        // R3 / R4 / R5 / R7: full address sweep per windowed scheme, both directions
        for (int m = 0; m < 3; m++) begin
            for (int a = 0; a < 2048; a++) begin
                for (int d = 0; d < 2; d++) begin
                    string tag;
                    if (m == 0)                      tag = "R3";
                    else if (m == 1)                 tag = "R4";
                    else if ((a % 16) inside {8, 9, 13}) tag = "R7";
                    else                             tag = "R5";
                    apply(tag, 2'(m), 1'b1, 1'b0, 11'(a), 1'b1, 1'b1, d[0], ~d[0]);
                end
            end
        end

        // R8 / R9 / R11: cancelling qualifiers on every window hit
        for (int m = 0; m < 3; m++) begin
            for (int k = 0; k < 10; k++) begin
                logic [10:0] a;
                if (k < 8)       a = (m == 0) ? 11'(11'h1F0 + k) : (m == 1) ? 11'(11'h170 + k) : 11'(k);
                else if (k == 8) a = (m == 0) ? 11'h3F6 : (m == 1) ? 11'h376 : 11'h00E;
                else             a = (m == 0) ? 11'h3F7 : (m == 1) ? 11'h377 : 11'h009;
                for (int d = 0; d < 2; d++) begin
                    apply("R8",  2'(m), 1'b1, 1'b1, a, 1'b1, 1'b1, d[0], ~d[0]);
                    apply("R9",  2'(m), 1'b0, 1'b0, a, 1'b1, 1'b1, d[0], ~d[0]);
                end
                apply("R11", 2'(m), 1'b1, 1'b0, a, 1'b1, 1'b1, 1'b0, 1'b0);
                apply("R11", 2'(m), 1'b1, 1'b0, a, 1'b1, 1'b1, 1'b1, 1'b1);
            end
        end

        // R10: chip-select scheme, scrambled upper bits and ignored qualifiers
        for (int a = 0; a < 64; a++) begin
            for (int c = 0; c < 4; c++) begin
                for (int s = 0; s < 4; s++) begin
                    apply("R10", 2'd3, 1'((a >> 4) & 1), 1'((a >> 3) & 1), 11'(a * 53),
                          c[0], c[1], s[0], s[1]);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule